// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds five CPU control registers: a status word, a saved copy of that status word, a saved program counter, a global base pointer and a vector base pointer. One register port is used for both reads and writes. It selects a register with a 3-bit code, and a privilege input decides which registers the current access may touch. A user-mode access to a protected register does nothing. The read returns zero and a violation flag is raised for one cycle.

When an exception is taken, the pipeline pulses a single-cycle entry strobe and supplies the current program counter. On that clock edge the bank copies the status word and the supplied program counter into the two save registers, both at once. The carry/test flag of the status word can be set or cleared by dedicated strobes in either mode. The vector base register and the status word are always driven out, for use by vector calculation and mode logic.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After synchronous active-low reset, `sr_out` is 32'h4000_0000 (privilege bit 30 set, all other bits clear), `vbr_out` is 0 and `viol` is low.
- R2: Select codes are 0 = status, 1 = saved status, 2 = saved PC, 3 = global base, 4 = vector base. With `priv`=1, a write stores `wdata` into the selected register at the clock edge, and a read (`rd_en`=1) shows it combinationally on `rdata`.
- R3: With `priv`=0, a write to codes 1, 2 or 4 leaves the register unchanged, and a read of them returns 0. In the cycle after any such access, `viol` is high, and it stays high for that one cycle only.
- R4: The global base register (code 3) can be written and read in either privilege mode, and such an access never raises `viol`.
- R5: With `priv`=0, a write to the status register changes only bits 0 (T), 1 (S), 8 (Q) and 9 (M). Every other bit keeps its value.
- R6: When `exc_take` is high at a clock edge, the saved status register receives the status value from before that edge and the saved PC receives `exc_pc`. The status register, including T, is not changed by the entry itself.
- R7: When a write to the saved status or saved PC register happens in the same cycle as `exc_take`, the exception save wins and the written data is discarded.
- R8: `t_set` forces bit 0 of the status register to 1 and `t_clr` forces it to 0, in either mode. If both are high, set wins. Either strobe overrides bit 0 of a simultaneous status write.
- R9: Codes 5, 6 and 7 read as 0, ignore writes and never raise `viol`.
- R10: `sr_out` and `vbr_out` always equal the current status and vector base registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| priv | input | 1 | 1 = privileged mode, 0 = user mode |
| sel | input | 3 | Register select code |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe for the selected register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational, zero when the read is not allowed) |
| exc_take | input | 1 | Exception-entry strobe, one cycle |
| exc_pc | input | 32 | Program counter to save on exception entry |
| t_set | input | 1 | Set the T flag |
| t_clr | input | 1 | Clear the T flag |
| vbr_out | output | 32 | Vector base register value |
| sr_out | output | 32 | Status register value |
| viol | output | 1 | Registered access-violation pulse |

## Verification
A wrong status bit shows on `sr_out` one edge after the operation that corrupted it. A wrong vector base shows on `vbr_out` at the same point. Corruption in the save registers or the global base stays hidden until a privileged read, because the outputs do not show those registers. The bench therefore reads every register often, so a bad save shows within a few operations. A missed or extra violation shows on `viol` in the cycle right after the access.

// File: rtl/ctrl_reg_pkg.sv
// Package: shared select codes and status-bit positions for the control
// register bank. Assumes a status word of at least 31 bits.
package ctrl_reg_pkg;
    typedef enum logic [2:0] {
        SEL_SR  = 3'd0,
        SEL_SSR = 3'd1,
        SEL_SPC = 3'd2,
        SEL_GBR = 3'd3,
        SEL_VBR = 3'd4
    } reg_sel_e;

    localparam int BIT_T  = 0;
    localparam int BIT_S  = 1;
    localparam int BIT_Q  = 8;
    localparam int BIT_M  = 9;
    localparam int BIT_MD = 30;
endpackage

// File: rtl/crb_access_gate.sv
// Access gate: decodes the select code into per-register write enables and
// a read permission, and registers a one-cycle violation pulse for user-mode
// accesses to protected registers. Assumes one access per cycle.
module crb_access_gate
    import ctrl_reg_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             priv,
    input  logic [SEL_W-1:0] sel,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             we_sr,
    output logic             we_ssr,
    output logic             we_spc,
    output logic             we_gbr,
    output logic             we_vbr,
    output logic             rd_ok,
    output logic             viol
);
    logic is_sr, is_ssr, is_spc, is_gbr, is_vbr;
    logic protected_sel, known_sel, denied;

    // decode the select code and the privilege check
    always_comb begin
        is_sr         = (sel == SEL_SR);
        is_ssr        = (sel == SEL_SSR);
        is_spc        = (sel == SEL_SPC);
        is_gbr        = (sel == SEL_GBR);
        is_vbr        = (sel == SEL_VBR);
        protected_sel = is_ssr | is_spc | is_vbr;
        known_sel     = is_sr | protected_sel | is_gbr;
        denied        = protected_sel & ~priv;
        we_sr         = wr_en & is_sr;
        we_gbr        = wr_en & is_gbr;
        we_ssr        = wr_en & is_ssr & priv;
        we_spc        = wr_en & is_spc & priv;
        we_vbr        = wr_en & is_vbr & priv;
        rd_ok         = rd_en & known_sel & ~denied;
    end

    // register the violation pulse
    always_ff @(posedge clk) begin
        if (!rst_n) viol <= 1'b0;
        else        viol <= (wr_en | rd_en) & denied;
    end

    // R3: user mode never produces a protected write enable
    assert_no_user_protected_write_R3: assert property (@(posedge clk)
        disable iff (!rst_n) !priv |-> !(we_ssr | we_spc | we_vbr));

    // R9: codes beyond the map never raise the violation flag
    assert_unmapped_no_viol_R9: assert property (@(posedge clk)
        disable iff (!rst_n) (sel > SEL_VBR) |=> !viol);
endmodule

// File: rtl/crb_status_reg.sv
// Status register: takes full writes in privileged mode and masked writes
// in user mode, and applies the T-flag strobes last. Assumes DATA_W > 30.
module crb_status_reg
    import ctrl_reg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              user_mode,
    input  logic [DATA_W-1:0] wdata,
    input  logic              t_set,
    input  logic              t_clr,
    output logic [DATA_W-1:0] sr_q
);
    localparam logic [DATA_W-1:0] UMASK = (DATA_W'(1) << BIT_T) | (DATA_W'(1) << BIT_S)
                                        | (DATA_W'(1) << BIT_Q) | (DATA_W'(1) << BIT_M);
    localparam logic [DATA_W-1:0] SR_RST = DATA_W'(1) << BIT_MD;

    logic [DATA_W-1:0] sr_nxt;

    // next status value: write (masked in user mode), then T strobes
    always_comb begin
        sr_nxt = sr_q;
        if (we) sr_nxt = user_mode ? ((sr_q & ~UMASK) | (wdata & UMASK)) : wdata;
        if (t_set)      sr_nxt[BIT_T] = 1'b1;
        else if (t_clr) sr_nxt[BIT_T] = 1'b0;
    end

    // status register flop
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= SR_RST;
        else        sr_q <= sr_nxt;
    end

    // R5: user writes keep every unmasked bit
    assert_user_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && user_mode) |=> ((sr_q & ~UMASK) == $past(sr_q & ~UMASK)));

    // R8: the set strobe always leaves T high
    assert_t_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        t_set |=> sr_q[BIT_T]);

    // R8: clear without set always leaves T low
    assert_t_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (t_clr && !t_set) |=> !sr_q[BIT_T]);
endmodule

// File: rtl/crb_save_regs.sv
// Save registers: capture status and PC on exception entry, and otherwise
// take privileged writes. The exception capture has priority over a write.
module crb_save_regs #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_take,
    input  logic [DATA_W-1:0] exc_pc,
    input  logic [DATA_W-1:0] sr_in,
    input  logic              we_ssr,
    input  logic              we_spc,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ssr_q,
    output logic [DATA_W-1:0] spc_q
);
    // saved status: exception capture first, then write
    always_ff @(posedge clk) begin
        if (!rst_n)        ssr_q <= '0;
        else if (exc_take) ssr_q <= sr_in;
        else if (we_ssr)   ssr_q <= wdata;
    end

    // saved PC: exception capture first, then write
    always_ff @(posedge clk) begin
        if (!rst_n)        spc_q <= '0;
        else if (exc_take) spc_q <= exc_pc;
        else if (we_spc)   spc_q <= wdata;
    end

    // R6, R7: status is captured on entry, whatever else is written
    assert_ssr_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (ssr_q == $past(sr_in)));

    // R6, R7: PC is captured on entry, whatever else is written
    assert_spc_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (spc_q == $past(exc_pc)));
endmodule

// File: rtl/crb_base_regs.sv
// Base registers: the global base (open to all modes) and the vector base
// (privileged writes only, enforced by the gate). The vector base resets to 0.
module crb_base_regs #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_gbr,
    input  logic              we_vbr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] gbr_q,
    output logic [DATA_W-1:0] vbr_q
);
    // global base: reset value is not part of the contract
    always_ff @(posedge clk) begin
        if (!rst_n)      gbr_q <= '0;
        else if (we_gbr) gbr_q <= wdata;
    end

    // vector base: defined reset to zero
    always_ff @(posedge clk) begin
        if (!rst_n)      vbr_q <= '0;
        else if (we_vbr) vbr_q <= wdata;
    end

    // R2: the vector base moves only on its write enable
    assert_vbr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_vbr |=> $stable(vbr_q));
endmodule

// File: rtl/ctrl_reg_bank.sv
// Top: privileged control register bank. Joins the access gate, status,
// save and base registers, and muxes the read port. Assumes single-cycle
// exception strobes from the pipeline.
module ctrl_reg_bank
    import ctrl_reg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              priv,
    input  logic [SEL_W-1:0]  sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              exc_take,
    input  logic [DATA_W-1:0] exc_pc,
    input  logic              t_set,
    input  logic              t_clr,
    output logic [DATA_W-1:0] vbr_out,
    output logic [DATA_W-1:0] sr_out,
    output logic              viol
);
    logic we_sr, we_ssr, we_spc, we_gbr, we_vbr, rd_ok;
    logic [DATA_W-1:0] sr_q, ssr_q, spc_q, gbr_q, vbr_q;

    crb_access_gate #(.SEL_W(SEL_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .priv(priv), .sel(sel),
        .wr_en(wr_en), .rd_en(rd_en),
        .we_sr(we_sr), .we_ssr(we_ssr), .we_spc(we_spc),
        .we_gbr(we_gbr), .we_vbr(we_vbr), .rd_ok(rd_ok), .viol(viol)
    );

    crb_status_reg #(.DATA_W(DATA_W)) u_sr (
        .clk(clk), .rst_n(rst_n), .we(we_sr), .user_mode(~priv),
        .wdata(wdata), .t_set(t_set), .t_clr(t_clr), .sr_q(sr_q)
    );

    crb_save_regs #(.DATA_W(DATA_W)) u_save (
        .clk(clk), .rst_n(rst_n), .exc_take(exc_take), .exc_pc(exc_pc),
        .sr_in(sr_q), .we_ssr(we_ssr), .we_spc(we_spc), .wdata(wdata),
        .ssr_q(ssr_q), .spc_q(spc_q)
    );

    crb_base_regs #(.DATA_W(DATA_W)) u_base (
        .clk(clk), .rst_n(rst_n), .we_gbr(we_gbr), .we_vbr(we_vbr),
        .wdata(wdata), .gbr_q(gbr_q), .vbr_q(vbr_q)
    );

    // read mux, zero unless the read is permitted
    always_comb begin
        rdata = '0;
        if (rd_ok) begin
            case (sel)
                SEL_SR:  rdata = sr_q;
                SEL_SSR: rdata = ssr_q;
                SEL_SPC: rdata = spc_q;
                SEL_GBR: rdata = gbr_q;
                SEL_VBR: rdata = vbr_q;
                default: rdata = '0;
            endcase
        end
    end

    // drive the always-visible outputs
    assign vbr_out = vbr_q;
    assign sr_out  = sr_q;

    // R3: a violation only follows a user-mode cycle
    assert_viol_user_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $past(!priv));

    // R6: entry alone leaves the T flag as it was
    assert_t_kept_on_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && !t_set && !t_clr && !we_sr) |=> $stable(sr_q[BIT_T]));

    // R4: global base accesses never flag a violation
    assert_gbr_no_viol_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_GBR) |=> !viol);
endmodule

// File: tb/ctrl_reg_bank_test.sv
// Bench: directed corner cases, then seeded random operations checked
// against a register model held in the bench.
module ctrl_reg_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        priv = 1'b1;
    logic [2:0]  sel = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = '0, exc_pc = '0;
    logic        exc_take = 1'b0, t_set = 1'b0, t_clr = 1'b0;
    logic [31:0] rdata, vbr_out, sr_out;
    logic        viol;

    int tests = 0, fails = 0, cyc = 0;
    logic [31:0] m_sr, m_ssr, m_spc, m_gbr, m_vbr;
    localparam logic [31:0] UM = 32'h0000_0303;

    ctrl_reg_bank uut (
        .clk(clk), .rst_n(rst_n), .priv(priv), .sel(sel), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .exc_take(exc_take),
        .exc_pc(exc_pc), .t_set(t_set), .t_clr(t_clr), .vbr_out(vbr_out),
        .sr_out(sr_out), .viol(viol)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            finish_run();
        end
    end

    function automatic logic [31:0] exp_read(input logic p, input logic [2:0] s);
        case (s)
            3'd0: return m_sr;
            3'd1: return p ? m_ssr : 32'h0;
            3'd2: return p ? m_spc : 32'h0;
            3'd3: return m_gbr;
            3'd4: return p ? m_vbr : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic is_denied(input logic p, input logic [2:0] s, input logic w, input logic r);
        return (w | r) & ~p & (s == 3'd1 || s == 3'd2 || s == 3'd4);
    endfunction

    // one operation: drive at negedge, check read, clock, update model, check outputs
    task automatic op(input string req, input logic p, input logic [2:0] s, input logic w,
                      input logic r, input logic [31:0] d, input logic ex,
                      input logic [31:0] pc, input logic ts, input logic tc);
        logic [31:0] old_sr;
        logic        exp_v;
        @(negedge clk);
        priv = p; sel = s; wr_en = w; rd_en = r; wdata = d;
        exc_take = ex; exc_pc = pc; t_set = ts; t_clr = tc;
        #1;
        if (r) check(req, rdata, exp_read(p, s));
        exp_v  = is_denied(p, s, w, r);
        old_sr = m_sr;
        if (w && s == 3'd0) m_sr = p ? d : ((m_sr & ~UM) | (d & UM));
        if (ts) m_sr[0] = 1'b1; else if (tc) m_sr[0] = 1'b0;
        if (ex) m_ssr = old_sr; else if (w && p && s == 3'd1) m_ssr = d;
        if (ex) m_spc = pc;     else if (w && p && s == 3'd2) m_spc = d;
        if (w && s == 3'd3) m_gbr = d;
        if (w && p && s == 3'd4) m_vbr = d;
        @(posedge clk); #1;
        check({req, " viol"}, {31'h0, viol}, {31'h0, exp_v});
        check("R10 sr_out", sr_out, m_sr);
        check("R10 vbr_out", vbr_out, m_vbr);
        @(negedge clk);
        wr_en = 0; rd_en = 0; exc_take = 0; t_set = 0; t_clr = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_sr = 32'h4000_0000; m_vbr = '0; m_ssr = '0; m_spc = '0; m_gbr = '0;
        @(posedge clk); #1;
        check("R1 sr reset", sr_out, 32'h4000_0000);
        check("R1 vbr reset", vbr_out, 32'h0);
        check("R1 viol reset", {31'h0, viol}, 32'h0);

        // R2: privileged writes and read-back of all five registers
        op("R2", 1, 3'd1, 1, 0, 32'h1111_2222, 0, 0, 0, 0);
        op("R2", 1, 3'd2, 1, 0, 32'h3333_4444, 0, 0, 0, 0);
        op("R2", 1, 3'd3, 1, 0, 32'h5555_6666, 0, 0, 0, 0);
        op("R2", 1, 3'd4, 1, 0, 32'h8000_1000, 0, 0, 0, 0);
        op("R2", 1, 3'd0, 1, 0, 32'h4000_00F0, 0, 0, 0, 0);
        for (int s = 0; s < 5; s++) op("R2 read", 1, 3'(s), 0, 1, 0, 0, 0, 0, 0);

        // R3: user access to protected registers
        op("R3", 0, 3'd4, 1, 0, 32'hDEAD_BEEF, 0, 0, 0, 0);
        op("R3", 0, 3'd1, 1, 1, 32'hDEAD_BEEF, 0, 0, 0, 0);
        op("R3", 0, 3'd2, 0, 1, 0, 0, 0, 0, 0);
        op("R3 pulse ends", 1, 3'd0, 0, 0, 0, 0, 0, 0, 0);
        op("R3 readback", 1, 3'd4, 0, 1, 0, 0, 0, 0, 0);
        op("R3 readback", 1, 3'd1, 0, 1, 0, 0, 0, 0, 0);

        // R4: global base in user mode
        op("R4", 0, 3'd3, 1, 0, 32'hCAFE_0003, 0, 0, 0, 0);
        op("R4", 0, 3'd3, 0, 1, 0, 0, 0, 0, 0);

        // R5: user write of all ones, then all zeros, to status
        op("R5", 0, 3'd0, 1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
        op("R5", 0, 3'd0, 1, 1, 32'h0000_0000, 0, 0, 0, 0);
        op("R5", 0, 3'd0, 0, 1, 0, 0, 0, 0, 0);

        // R6, R7: exception entry alone, then with save-register writes
        op("R6", 1, 3'd0, 0, 0, 0, 1, 32'h0000_ABC0, 0, 0);
        op("R6", 1, 3'd1, 0, 1, 0, 0, 0, 0, 0);
        op("R6", 1, 3'd2, 0, 1, 0, 0, 0, 0, 0);
        op("R7", 1, 3'd1, 1, 0, 32'h7777_7777, 1, 32'h0000_1230, 0, 0);
        op("R7", 1, 3'd2, 1, 0, 32'h7777_7777, 1, 32'h0000_4560, 0, 0);
        op("R7", 1, 3'd1, 0, 1, 0, 0, 0, 0, 0);
        op("R7", 1, 3'd2, 0, 1, 0, 0, 0, 0, 0);

        // R8: flag strobes in both modes, together, and over a status write
        op("R8", 0, 3'd0, 0, 0, 0, 0, 0, 1, 0);
        op("R8", 0, 3'd0, 0, 0, 0, 0, 0, 0, 1);
        op("R8", 1, 3'd0, 0, 0, 0, 0, 0, 1, 1);
        op("R8", 1, 3'd0, 1, 0, 32'h4000_0000, 0, 0, 1, 0);
        op("R8", 0, 3'd0, 1, 0, 32'h0000_0001, 0, 0, 0, 1);
        op("R8", 1, 3'd0, 0, 0, 0, 1, 32'h10, 1, 0);

        // R9: unmapped codes
        for (int s = 5; s < 8; s++) begin
            op("R9", 1, 3'(s), 1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
            op("R9", 0, 3'(s), 1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
        end
        for (int s = 0; s < 5; s++) op("R9 no change", 1, 3'(s), 0, 1, 0, 0, 0, 0, 0);

        // random mix against the model
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] rs;
            rs = 3'($urandom_range(0, 7));
            op("R2/R3/R5/R6 random", 1'($urandom_range(0, 1)), rs,
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom(),
               ($urandom_range(0, 7) == 0), $urandom(),
               ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0));
        end
        finish_run();
    end
endmodule